// File: doc/BRIEF.md
# Chained Transfer Descriptor Loader

This block reloads one DMA channel when the channel engine reports that the current transfer has run out. The engine raises a completion request and presents three things: the channel index, that channel's link pointer and its control word. If the pointer is non-null, the loader reads a four-word descriptor from memory through a simple 32-bit read master. It then presents the new source, destination, control and link values on a one-cycle update strobe, and the engine writes them into the channel's registers.

If the pointer is null, no memory access takes place. The update strobe instead carries a disable indication, and the engine clears the channel's enable bit. In both cases a terminal-count flag for the channel is raised alongside the update when the top bit of the control word then in effect is set.

While the loader is working it holds busy. The engine uses busy to hold off new element transfers.

Top module: `chain_loader`

## Requirements
- R1: After reset, busy, memReq, updValid and tcSet are all 0.
- R2: For a non-null pointer, exactly four reads are issued, one at a time, in this order: base+0 (source), base+4 (destination), base+12 (control), base+8 (link). The link word is therefore fetched last, and every address is relative to the old pointer.
- R3: The base is the pointer with its two low bits cleared. memAddr[1:0] is always 0, and a pointer whose bits 31:2 are all zero counts as null.
- R4: The loaded values are presented as follows: updSrc is the word at base+0, updDst the word at base+4, updLink the word at base+8 and updCtrl the word at base+12. Each word is little-endian, with the byte at the lowest address in memRspData[7:0].
- R5: For a null pointer, no read is issued. updValid rises with updDisable=1 and updLink=0 in the cycle after the request is accepted, and updCtrl equals the curCtrl presented with the request.
- R6: tcSet is high during the update strobe exactly when bit 31 of updCtrl is 1. On a reload this is the new control word; on a disable it is the current one. tcSet is never high outside the update strobe.
- R7: busy rises in the cycle after an accepted request and stays high through the update cycle. A doneReq raised while busy is high is ignored and changes neither updChan nor the number of updates.
- R8: memReq, once raised, holds with a stable memAddr until memGnt. After a grant, no new request is raised until memRspValid has returned that word.
- R9: updValid is a single-cycle pulse, followed by busy low in the next cycle. updChan equals the reqChan captured with the request.
- R10: On a reload, updDisable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| doneReq | input | 1 | Completion request from the channel engine |
| reqChan | input | CHAN_W | Channel index of the request |
| curLink | input | 32 | Current link pointer of that channel |
| curCtrl | input | 32 | Current control word of that channel |
| busy | output | 1 | Loader is active |
| memReq | output | 1 | Word read request |
| memAddr | output | 32 | Word-aligned read address |
| memGnt | input | 1 | Read request accepted |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 32 | Read data, little-endian lanes |
| updValid | output | 1 | One-cycle channel update strobe |
| updChan | output | CHAN_W | Channel to update |
| updSrc | output | 32 | New source address |
| updDst | output | 32 | New destination address |
| updCtrl | output | 32 | Control word in effect |
| updLink | output | 32 | New link pointer |
| updDisable | output | 1 | Clear channel enable (null pointer) |
| tcSet | output | 1 | Set terminal-count flag for updChan |

## Verification
The checks assume that the memory side never returns memRspValid unless a granted read is outstanding, and never grants when no request is up. The bench's responder enforces this by tracking grants itself and by inserting grant waits and response latency only within one outstanding read. A doneReq during busy is treated as a harmless input. The bench provokes it deliberately and observes through updChan and the update count that it was dropped. Null and non-null pointers are swept with every low-bit pattern, so that alignment and null detection are exercised together.

// File: rtl/chain_loader_pkg.sv
package chain_loader_pkg;
  localparam int WORD_W = 32;
  localparam int ALIGN_W = 2;
  localparam int TC_BIT = 31;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_SRC, ST_RD_DST, ST_RD_CTRL, ST_RD_LINK, ST_DONE
  } ldState_e;

  // Word selector; value times four is the byte offset inside a descriptor.
  typedef enum logic [1:0] {
    W_SRC = 2'd0, W_DST = 2'd1, W_LINK = 2'd2, W_CTRL = 2'd3
  } wordSel_e;

  typedef struct packed {
    logic     start;    // capture request context
    logic     capWord;  // latch response data into selected field
    wordSel_e sel;      // word being fetched
  } ldStrb_t;
endpackage

// File: rtl/chain_loader_ctrl.sv
module chain_loader_ctrl
  import chain_loader_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    doneReq,
  input  logic    linkNull,
  input  logic    memGnt,
  input  logic    memRspValid,
  output ldStrb_t strb,
  output logic    memReq,
  output logic    busy,
  output logic    updValid
);
  ldState_e state, stateNxt;
  logic pending, pendingNxt;
  logic fetching;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      pending <= 1'b0;
    end else begin
      state   <= stateNxt;
      pending <= pendingNxt;
    end
  end

  always_comb begin
    unique case (state)
      ST_RD_SRC:  strb.sel = W_SRC;
      ST_RD_DST:  strb.sel = W_DST;
      ST_RD_CTRL: strb.sel = W_CTRL;
      default:    strb.sel = W_LINK;
    endcase
  end

  assign fetching = (state == ST_RD_SRC) || (state == ST_RD_DST) ||
                    (state == ST_RD_CTRL) || (state == ST_RD_LINK);
  assign memReq   = fetching && !pending;
  assign busy     = (state != ST_IDLE);
  assign updValid = (state == ST_DONE);

  always_comb begin
    stateNxt     = state;
    pendingNxt   = pending;
    strb.start   = 1'b0;
    strb.capWord = 1'b0;
    if (state == ST_IDLE) begin
      if (doneReq) begin
        strb.start = 1'b1;
        stateNxt   = linkNull ? ST_DONE : ST_RD_SRC;
      end
    end else if (state == ST_DONE) begin
      stateNxt = ST_IDLE;
    end else begin
      if (memReq && memGnt) pendingNxt = 1'b1;
      if (pending && memRspValid) begin
        strb.capWord = 1'b1;
        pendingNxt   = 1'b0;
        unique case (state)
          ST_RD_SRC:  stateNxt = ST_RD_DST;
          ST_RD_DST:  stateNxt = ST_RD_CTRL;
          ST_RD_CTRL: stateNxt = ST_RD_LINK;
          default:    stateNxt = ST_DONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/chain_loader_path.sv
module chain_loader_path
  import chain_loader_pkg::*;
#(
  parameter int CHAN_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ldStrb_t           strb,
  input  logic [CHAN_W-1:0] reqChan,
  input  logic [WORD_W-1:0] curLink,
  input  logic [WORD_W-1:0] curCtrl,
  input  logic [WORD_W-1:0] memRspData,
  output logic              linkNull,
  output logic [WORD_W-1:0] memAddr,
  output logic [CHAN_W-1:0] updChan,
  output logic [WORD_W-1:0] updSrc,
  output logic [WORD_W-1:0] updDst,
  output logic [WORD_W-1:0] updCtrl,
  output logic [WORD_W-1:0] updLink,
  output logic              updDisable,
  output logic              tcFlag
);
  localparam int HI_W = WORD_W - ALIGN_W;

  logic [HI_W-1:0]   baseHi;
  logic [WORD_W-1:0] baseAddr;
  logic [WORD_W-1:0] wordOfs;

  assign linkNull = (curLink[WORD_W-1:ALIGN_W] == '0);
  assign baseAddr = {baseHi, {ALIGN_W{1'b0}}};
  assign wordOfs  = WORD_W'({strb.sel, {ALIGN_W{1'b0}}});
  assign memAddr  = baseAddr + wordOfs;
  assign tcFlag   = updCtrl[TC_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseHi     <= '0;
      updChan    <= '0;
      updSrc     <= '0;
      updDst     <= '0;
      updCtrl    <= '0;
      updLink    <= '0;
      updDisable <= 1'b0;
    end else if (strb.start) begin
      baseHi     <= curLink[WORD_W-1:ALIGN_W];
      updChan    <= reqChan;
      updCtrl    <= curCtrl;
      updLink    <= '0;
      updDisable <= linkNull;
    end else if (strb.capWord) begin
      unique case (strb.sel)
        W_SRC:   updSrc  <= memRspData;
        W_DST:   updDst  <= memRspData;
        W_CTRL:  updCtrl <= memRspData;
        default: updLink <= memRspData;
      endcase
    end
  end
endmodule

// File: rtl/chain_loader.sv
module chain_loader
  import chain_loader_pkg::*;
#(
  parameter int CHAN_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              doneReq,
  input  logic [CHAN_W-1:0] reqChan,
  input  logic [31:0]       curLink,
  input  logic [31:0]       curCtrl,
  output logic              busy,
  output logic              memReq,
  output logic [31:0]       memAddr,
  input  logic              memGnt,
  input  logic              memRspValid,
  input  logic [31:0]       memRspData,
  output logic              updValid,
  output logic [CHAN_W-1:0] updChan,
  output logic [31:0]       updSrc,
  output logic [31:0]       updDst,
  output logic [31:0]       updCtrl,
  output logic [31:0]       updLink,
  output logic              updDisable,
  output logic              tcSet
);
  ldStrb_t strb;
  logic linkNull;
  logic tcFlag;

  chain_loader_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .doneReq(doneReq), .linkNull(linkNull),
    .memGnt(memGnt), .memRspValid(memRspValid), .strb(strb),
    .memReq(memReq), .busy(busy), .updValid(updValid)
  );

  chain_loader_path #(.CHAN_W(CHAN_W)) u_path (
    .clk(clk), .rstN(rstN), .strb(strb), .reqChan(reqChan),
    .curLink(curLink), .curCtrl(curCtrl), .memRspData(memRspData),
    .linkNull(linkNull), .memAddr(memAddr), .updChan(updChan),
    .updSrc(updSrc), .updDst(updDst), .updCtrl(updCtrl),
    .updLink(updLink), .updDisable(updDisable), .tcFlag(tcFlag)
  );

  assign tcSet = updValid && tcFlag;
endmodule

// File: rtl/chain_loader_chk.sv
module chain_loader_chk #(
  parameter int CHAN_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              doneReq,
  input logic [31:0]       curLink,
  input logic              busy,
  input logic              memReq,
  input logic [31:0]       memAddr,
  input logic              memGnt,
  input logic              updValid,
  input logic              updDisable,
  input logic [31:0]       updCtrl,
  input logic              tcSet
);
  a_r8_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memGnt |=> memReq && $stable(memAddr));
  a_r8_one_out: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memGnt |=> !memReq);
  a_r3_aligned: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> memAddr[1:0] == 2'b00);
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReq && !updValid);
  a_r7_busy_rise: assert property (@(posedge clk) disable iff (!rstN)
    doneReq && !busy |=> busy);
  a_r9_pulse: assert property (@(posedge clk) disable iff (!rstN)
    updValid |=> !updValid && !busy);
  a_r5_null_disable: assert property (@(posedge clk) disable iff (!rstN)
    doneReq && !busy && curLink[31:2] == 30'd0 |=> updValid && updDisable);
  a_r6_tc_match: assert property (@(posedge clk) disable iff (!rstN)
    updValid |-> tcSet == updCtrl[31]);
  a_r6_tc_only_upd: assert property (@(posedge clk) disable iff (!rstN)
    tcSet |-> updValid);
endmodule

bind chain_loader chain_loader_chk #(.CHAN_W(CHAN_W)) u_chk (
  .clk(clk), .rstN(rstN), .doneReq(doneReq), .curLink(curLink),
  .busy(busy), .memReq(memReq), .memAddr(memAddr), .memGnt(memGnt),
  .updValid(updValid), .updDisable(updDisable), .updCtrl(updCtrl),
  .tcSet(tcSet)
);

// File: tb/sim_chain_loader.sv
`timescale 1ns/1ps
module sim_chain_loader;
  localparam int CHAN_W = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic doneReq = 1'b0;
  logic [CHAN_W-1:0] reqChan = '0;
  logic [31:0] curLink = '0, curCtrl = '0;
  logic busy, memReq, memGnt = 1'b0, memRspValid = 1'b0;
  logic [31:0] memAddr, memRspData = '0;
  logic updValid, updDisable, tcSet;
  logic [CHAN_W-1:0] updChan;
  logic [31:0] updSrc, updDst, updCtrl, updLink;

  int checks = 0, failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  chain_loader #(.CHAN_W(CHAN_W)) u0 (
    .clk(clk), .rstN(rstN), .doneReq(doneReq), .reqChan(reqChan),
    .curLink(curLink), .curCtrl(curCtrl), .busy(busy), .memReq(memReq),
    .memAddr(memAddr), .memGnt(memGnt), .memRspValid(memRspValid),
    .memRspData(memRspData), .updValid(updValid), .updChan(updChan),
    .updSrc(updSrc), .updDst(updDst), .updCtrl(updCtrl), .updLink(updLink),
    .updDisable(updDisable), .tcSet(tcSet)
  );

  function automatic logic [7:0] byteAt(input logic [31:0] a);
    return 8'((a * 7 + 13) ^ (a >> 8) ^ (a >> 16) ^ (a >> 3));
  endfunction
  function automatic logic [31:0] wordAt(input logic [31:0] a);
    return {byteAt(a + 3), byteAt(a + 2), byteAt(a + 1), byteAt(a)};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory responder
  int latency = 0, gntDelay = 0;
  int reqCount = 0, updCount = 0;
  logic [31:0] reqLog [4];
  logic [31:0] lastAddr = '0;
  bit gntGiven = 0, outstanding = 0;
  int latCnt = 0, waitCnt = 0;

  always @(negedge clk) begin
    memRspValid = 1'b0;
    if (gntGiven) begin
      gntGiven = 0; memGnt = 1'b0; outstanding = 1; latCnt = latency;
    end
    if (outstanding) begin
      if (latCnt == 0) begin
        memRspValid = 1'b1; memRspData = wordAt(lastAddr); outstanding = 0;
      end else latCnt--;
    end else if (memReq && !gntGiven) begin
      if (waitCnt < gntDelay) waitCnt++;
      else begin
        waitCnt = 0; memGnt = 1'b1; gntGiven = 1; lastAddr = memAddr;
        if (reqCount < 4) reqLog[reqCount] = memAddr;
        reqCount++;
      end
    end
    if (updValid) updCount++;
  end

  task automatic runLoad(input int ch, input logic [31:0] link,
                         input logic [31:0] ctrl, input bit inject);
    logic [31:0] base;
    bit isNull;
    int guard;
    base = {link[31:2], 2'b00};
    isNull = (link[31:2] == 30'd0);
    @(negedge clk);
    reqCount = 0; updCount = 0;
    doneReq = 1'b1; reqChan = CHAN_W'(ch); curLink = link; curCtrl = ctrl;
    @(negedge clk);
    doneReq = 1'b0; curLink = 32'hdead_0000; curCtrl = 32'h0;
    chk(busy == 1'b1, "R7 busy after request", {31'd0, busy}, 32'd1);
    if (isNull) begin
      chk(updValid == 1'b1, "R5 null update timing", {31'd0, updValid}, 32'd1);
    end else if (inject) begin
      doneReq = 1'b1; reqChan = CHAN_W'(ch + 1); curLink = 32'h0;
      @(negedge clk);
      doneReq = 1'b0;
    end
    guard = 0;
    while (!updValid && guard < 200) begin
      @(negedge clk); guard++;
    end
    chk(updValid == 1'b1, "R9 update seen", {31'd0, updValid}, 32'd1);
    chk(updChan == CHAN_W'(ch), "R9 channel", 32'(updChan), 32'(ch));
    if (isNull) begin
      chk(updDisable == 1'b1, "R5 disable", {31'd0, updDisable}, 32'd1);
      chk(reqCount == 0, "R5 no read", 32'(reqCount), 32'd0);
      chk(updLink == 32'd0, "R5 link zero", updLink, 32'd0);
      chk(updCtrl == ctrl, "R5 ctrl kept", updCtrl, ctrl);
      chk(tcSet == ctrl[31], "R6 tc on disable", {31'd0, tcSet}, {31'd0, ctrl[31]});
    end else begin
      chk(updDisable == 1'b0, "R10 no disable", {31'd0, updDisable}, 32'd0);
      chk(reqCount == 4, "R2 read count", 32'(reqCount), 32'd4);
      chk(reqLog[0] == base, "R2 R3 addr src", reqLog[0], base);
      chk(reqLog[1] == base + 4, "R2 addr dst", reqLog[1], base + 4);
      chk(reqLog[2] == base + 12, "R2 addr ctrl", reqLog[2], base + 12);
      chk(reqLog[3] == base + 8, "R2 addr link last", reqLog[3], base + 8);
      chk(updSrc == wordAt(base), "R4 src", updSrc, wordAt(base));
      chk(updDst == wordAt(base + 4), "R4 dst", updDst, wordAt(base + 4));
      chk(updLink == wordAt(base + 8), "R4 link", updLink, wordAt(base + 8));
      chk(updCtrl == wordAt(base + 12), "R4 ctrl", updCtrl, wordAt(base + 12));
      chk(tcSet == wordAt(base + 12) >> 31, "R6 tc on reload",
          {31'd0, tcSet}, wordAt(base + 12) >> 31);
    end
    @(negedge clk);
    chk(updValid == 1'b0 && busy == 1'b0, "R9 pulse end",
        {30'd0, updValid, busy}, 32'd0);
    chk(updCount == 1, "R7 single update", 32'(updCount), 32'd1);
    chk(tcSet == 1'b0, "R6 tc idle", {31'd0, tcSet}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(busy == 0 && memReq == 0 && updValid == 0 && tcSet == 0,
        "R1 reset state", {28'd0, busy, memReq, updValid, tcSet}, 32'd0);
    // null pointers, all low-bit patterns (R5, R3)
    for (int ch = 0; ch < 8; ch++)
      for (int lo = 0; lo < 4; lo++)
        runLoad(ch, 32'(lo), {ch[0], 7'd0, 24'(ch * 5 + lo)}, 1'b0);
    // reloads: channel, pointer low bits, latency and grant wait (R2-R4, R6, R8, R10)
    for (int ch = 0; ch < 8; ch++)
      for (int lo = 0; lo < 4; lo++)
        for (int lat = 0; lat < 3; lat++) begin
          latency = lat;
          gntDelay = (ch + lo) % 2;
          runLoad(ch, 32'h0000_2000 + 32'((ch * 12 + lo * 3 + lat) * 16)
                  + 32'(ch << 20) + 32'(lo), 32'h0, lo == 2);
        end
    // pointer with only bit 2 set is non-null (R3)
    latency = 0; gntDelay = 0;
    runLoad(5, 32'h0000_0004, 32'h8000_0000, 1'b1);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule